// File: doc/BRIEF.md
# Byte-Lane Register Write Guard

This block stands between a single-cycle memory-mapped register bus and a bank of 32-bit peripheral registers. Every register word owns four soft-lock bits, one per byte lane. A write through the register's normal address to a locked lane is dropped for that lane and flagged as an error. Lock bits are written through a lock-byte area. Each lock byte carries the four lock bits in its low nibble and four matching write-enable bits in its high nibble, so a single write can set or clear any subset of lanes without disturbing the rest.

A second address window, the alias window, reaches the same registers. A write through it updates the register and then locks every lane it wrote. This gives "write then freeze" in one bus access.

A control word holds two bits:
- a sticky freeze bit, which can only be cleared by reset and which blocks all further lock-area and control writes;
- a user-permit bit, which opens the block to unprivileged accesses.

The register contents are presented in parallel to the peripheral logic behind the guard.

Requests use a valid strobe only. The block never applies back-pressure, because every request is accepted in the cycle it is presented. The response (`rsp_valid`, `rsp_err`, `rsp_rdata`) appears exactly one clock later. There is no ready signal on either side, and the requester must take each response in the cycle it is shown.

Top module: `rwp_guard`

## Requirements
- R1: After reset, every register, every lock bit, the freeze bit and the user-permit bit are 0. `rsp_valid` is 0 until a request is made.
- R2: A privileged write to a register's normal address (byte offset 4*n) updates exactly the byte lanes whose strobe is 1 and that are unlocked, and returns `rsp_err`=0. A read returns the register word.
- R3: A normal-address write that touches a locked lane leaves that lane unchanged, still writes the unlocked strobed lanes, and returns `rsp_err`=1.
- R4: In the lock area (base LOCK_OFS), the lock byte of word n sits at byte offset n XOR 3, that is at lane (n mod 4) XOR 3 of lock word n/4. In a lock byte, bit 4+i gates bit i: a written lock bit changes only where its enable bit is 1 in the same data. Enable bits read back as 0, and a lock bit reads back as 1 when set and 0 when clear.
- R5: A write through the alias window (base MIRROR_OFS + 4*n) updates the unlocked strobed lanes and then sets their lock bits. A read through the alias returns the register word.
- R6: The control word at CTRL_OFS has the freeze bit at bit 31 and the user-permit bit at bit 23. Writing 1 to bit 31 (lane 3 strobed) sets the freeze bit, and writing 0 never clears it. Bit 23 (lane 2 strobed) is read/write.
- R7: While the freeze bit is set, writes to the lock area and to the control word change nothing and return `rsp_err`=1.
- R8: An access with `req_priv`=0 while the user-permit bit is 0 has no effect and returns `rsp_err`=1 with `rsp_rdata`=0. Once the user-permit bit is 1, such accesses behave as privileged ones.
- R9: An access to an address outside the data, alias, lock and control windows returns `rsp_err`=1 and `rsp_rdata`=0. Write responses always carry `rsp_rdata`=0.
- R10: Each cycle with `req_valid`=1 produces exactly one response cycle with `rsp_valid`=1 on the next clock. Idle cycles produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged requester |
| req_addr | input | ADDR_W | Byte address, low two bits ignored |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte-lane write strobes |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Access rejected or partly dropped |
| rsp_rdata | output | 32 | Read data (0 on writes and errors) |
| periph_regs | output | 32*N_WORDS | Register contents, word n at bits 32n+31:32n |

## Verification
All results are due exactly one clock after the request. The response flags and read data are registered at the edge where the request is sampled. The state changes made by a write are visible to a request presented in the very next cycle. The bench drives a request on a falling edge and pushes the expected error flag and read data into a queue. A monitor pops one entry on each falling edge that shows `rsp_valid`, so each comparison lands one cycle after its stimulus. The effects of writes are checked by reads issued back-to-back after them.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_DATA   = 3'd1,
    RG_MIRROR = 3'd2,
    RG_LOCK   = 3'd3,
    RG_CTRL   = 3'd4
  } region_e;

  localparam int FREEZE_BIT = 31;
  localparam int PERMIT_BIT = 23;
  localparam int LANES      = 4;
endpackage

// File: rtl/rwp_decode.sv
module rwp_decode
  import rwp_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int N_WORDS    = 16,
  parameter int MIRROR_OFS = 'h400,
  parameter int LOCK_OFS   = 'h800,
  parameter int CTRL_OFS   = 'h900,
  localparam int IDX_W     = $clog2(N_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [31:0] SPAN = 32'(N_WORDS * 4);
  logic [31:0] a;

  always_comb begin
    a      = 32'(addr);
    region = RG_NONE;
    idx    = '0;
    if (a < SPAN) begin
      region = RG_DATA;
      idx    = IDX_W'(a >> 2);
    end else if (a >= 32'(MIRROR_OFS) && a < 32'(MIRROR_OFS) + SPAN) begin
      region = RG_MIRROR;
      idx    = IDX_W'((a - 32'(MIRROR_OFS)) >> 2);
    end else if (a >= 32'(LOCK_OFS) && a < 32'(LOCK_OFS) + 32'(N_WORDS)) begin
      region = RG_LOCK;
      idx    = IDX_W'((a - 32'(LOCK_OFS)) >> 2);
    end else if ((a >> 2) == (32'(CTRL_OFS) >> 2)) begin
      region = RG_CTRL;
    end
  end
endmodule

// File: rtl/rwp_reg_bank.sv
module rwp_reg_bank #(
  parameter int N_WORDS = 16,
  localparam int IDX_W  = $clog2(N_WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [31:0]            wdata,
  input  logic [3:0]             lane_we,
  output logic [N_WORDS*32-1:0]  regs_flat,
  output logic [31:0]            rdata
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [31:0] q;
    for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n)
          q[b*8 +: 8] <= '0;
        else if (we && lane_we[b] && idx == IDX_W'(w))
          q[b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
    assign regs_flat[w*32 +: 32] = q;
  end

  assign rdata = regs_flat[int'(idx)*32 +: 32];
endmodule

// File: rtl/rwp_lock_bank.sv
module rwp_lock_bank #(
  parameter int N_WORDS = 16,
  localparam int IDX_W  = $clog2(N_WORDS),
  localparam int LIDX_W = (N_WORDS / 4 > 1) ? $clog2(N_WORDS / 4) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lw_en,
  input  logic [LIDX_W-1:0]     lw_idx,
  input  logic [31:0]           wdata,
  input  logic [3:0]            strb,
  input  logic                  ms_en,
  input  logic [IDX_W-1:0]      ms_idx,
  input  logic [3:0]            ms_lanes,
  output logic [N_WORDS*4-1:0]  lock_flat,
  output logic [31:0]           lw_rdata
);
  logic [N_WORDS*4-1:0] lock_nxt;

  // Lock byte of word n lives in lane (n mod 4) xor 3 of lock word n/4.
  always_comb begin
    lock_nxt = lock_flat;
    for (int n = 0; n < N_WORDS; n++) begin
      if (lw_en && int'(lw_idx) == n / 4 && strb[(n % 4) ^ 3]) begin
        for (int i = 0; i < 4; i++) begin
          if (wdata[((n % 4) ^ 3) * 8 + 4 + i])
            lock_nxt[n*4 + i] = wdata[((n % 4) ^ 3) * 8 + i];
        end
      end
      if (ms_en && int'(ms_idx) == n)
        lock_nxt[n*4 +: 4] = lock_nxt[n*4 +: 4] | ms_lanes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock_flat <= '0;
    else        lock_flat <= lock_nxt;
  end

  for (genvar b = 0; b < 4; b++) begin : g_rd
    assign lw_rdata[b*8 +: 8] = {4'b0000, lock_flat[(int'(lw_idx)*4 + (b ^ 3))*4 +: 4]};
  end
endmodule

// File: rtl/rwp_guard.sv
module rwp_guard
  import rwp_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int N_WORDS    = 16,
  parameter int MIRROR_OFS = 'h400,
  parameter int LOCK_OFS   = 'h800,
  parameter int CTRL_OFS   = 'h900
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_priv,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  input  logic [3:0]             req_strb,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [31:0]            rsp_rdata,
  output logic [N_WORDS*32-1:0]  periph_regs
);
  localparam int IDX_W  = $clog2(N_WORDS);
  localparam int LIDX_W = (N_WORDS / 4 > 1) ? $clog2(N_WORDS / 4) : 1;

  region_e             region;
  logic [IDX_W-1:0]    idx;
  logic [N_WORDS*4-1:0] lock_flat;
  logic [31:0]         reg_rdata, lw_rdata, ctrl_word;
  logic                hard_lock_q, uaa_q;
  logic                user_ok, wr, is_word;
  logic [3:0]          cur_lock, lane_we, blocked;
  logic                err_d;
  logic [31:0]         rdata_d;

  rwp_decode #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .MIRROR_OFS(MIRROR_OFS),
               .LOCK_OFS(LOCK_OFS), .CTRL_OFS(CTRL_OFS)) u_dec (
    .addr(req_addr), .region(region), .idx(idx));

  assign user_ok  = req_priv | uaa_q;
  assign wr       = req_valid & user_ok & req_write;
  assign is_word  = (region == RG_DATA) || (region == RG_MIRROR);
  assign cur_lock = lock_flat[int'(idx)*4 +: 4];
  assign blocked  = req_strb & cur_lock;
  assign lane_we  = req_strb & ~cur_lock;

  rwp_reg_bank #(.N_WORDS(N_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr & is_word), .idx(idx),
    .wdata(req_wdata), .lane_we(lane_we), .regs_flat(periph_regs),
    .rdata(reg_rdata));

  rwp_lock_bank #(.N_WORDS(N_WORDS)) u_locks (
    .clk(clk), .rst_n(rst_n),
    .lw_en(wr & (region == RG_LOCK) & ~hard_lock_q),
    .lw_idx(LIDX_W'(idx)), .wdata(req_wdata), .strb(req_strb),
    .ms_en(wr & (region == RG_MIRROR)), .ms_idx(idx), .ms_lanes(lane_we),
    .lock_flat(lock_flat), .lw_rdata(lw_rdata));

  // Control word: sticky freeze bit, read/write user-permit bit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hard_lock_q <= 1'b0;
      uaa_q       <= 1'b0;
    end else if (wr && region == RG_CTRL && !hard_lock_q) begin
      if (req_strb[3] && req_wdata[FREEZE_BIT]) hard_lock_q <= 1'b1;
      if (req_strb[2]) uaa_q <= req_wdata[PERMIT_BIT];
    end
  end

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[FREEZE_BIT] = hard_lock_q;
    ctrl_word[PERMIT_BIT] = uaa_q;
  end

  always_comb begin
    err_d   = 1'b0;
    rdata_d = '0;
    if (req_valid) begin
      if (region == RG_NONE || !user_ok) begin
        err_d = 1'b1;
      end else if (req_write) begin
        if (is_word) err_d = |blocked;
        else         err_d = hard_lock_q;
      end else begin
        unique case (region)
          RG_DATA, RG_MIRROR: rdata_d = reg_rdata;
          RG_LOCK:            rdata_d = lw_rdata;
          RG_CTRL:            rdata_d = ctrl_word;
          default:            rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err_d;
      rsp_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/rwp_guard_chk.sv
module rwp_guard_chk #(
  parameter int N_WORDS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_priv,
  input logic                  rsp_valid,
  input logic                  rsp_err,
  input logic [31:0]           rsp_rdata,
  input logic                  hard_lock_q,
  input logic                  uaa_q,
  input logic [N_WORDS*4-1:0]  lock_flat
);
  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_user_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && !uaa_q) |=> (rsp_err && rsp_rdata == 32'h0));

  p_freeze_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock_q |=> hard_lock_q);

  p_permit_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock_q |=> $stable(uaa_q));

  p_locks_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(lock_flat));

  p_quiet_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_err);
endmodule

bind rwp_guard rwp_guard_chk #(.N_WORDS(N_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .hard_lock_q(hard_lock_q), .uaa_q(uaa_q), .lock_flat(lock_flat));

// File: tb/sim_rwp_guard.sv
`timescale 1ns/1ps
module sim_rwp_guard;
  localparam int ADDR_W  = 14;
  localparam int N_WORDS = 16;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b1;
  logic [ADDR_W-1:0]     req_addr = '0;
  logic [31:0]           req_wdata = '0;
  logic [3:0]            req_strb = '0;
  logic                  rsp_valid, rsp_err;
  logic [31:0]           rsp_rdata;
  logic [N_WORDS*32-1:0] periph_regs;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  bit          q_err[$];
  logic [31:0] q_rd[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  rwp_guard #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_strb(req_strb), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .periph_regs(periph_regs));

  // Driver: presents one request per falling edge and queues its expected response.
  task automatic acc(input bit w, input int addr, input logic [31:0] d,
                     input logic [3:0] s, input bit p, input bit e_err,
                     input logic [31:0] e_rd, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = ADDR_W'(addr);
    req_wdata = d; req_strb = s; req_priv = p;
    q_err.push_back(e_err); q_rd.push_back(e_rd); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // Monitor: response is due one cycle after its request.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      vectors++;
      if (q_err.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected response: actual rsp_valid=1 expected 0");
      end else begin
        automatic bit          e = q_err.pop_front();
        automatic logic [31:0] r = q_rd.pop_front();
        automatic string       t = q_tag.pop_front();
        if (rsp_err !== e || rsp_rdata !== r) begin
          fails++;
          $display("FAIL %s: actual err=%0b rdata=%08h expected err=%0b rdata=%08h",
                   t, rsp_err, rsp_rdata, e, r);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    vectors++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 rsp_valid after reset: actual %0b expected 0", rsp_valid);
    end
    // R1 reset state
    acc(0, 'h00C, 0, 0, 1, 0, 32'h0, "R1 reg3 reset");
    acc(0, 'h800, 0, 0, 1, 0, 32'h0, "R1 lockword0 reset");
    acc(0, 'h900, 0, 0, 1, 0, 32'h0, "R1 ctrl reset");
    // R2 plain writes with strobes
    acc(1, 'h008, 32'hA1B2C3D4, 4'hF, 1, 0, 0, "R2 full write");
    acc(0, 'h008, 0, 0, 1, 0, 32'hA1B2C3D4, "R2 readback");
    acc(1, 'h008, 32'h000000EE, 4'h1, 1, 0, 0, "R2 lane0 write");
    acc(0, 'h008, 0, 0, 1, 0, 32'hA1B2C3EE, "R2 partial readback");
    // R4 lock word 2 lane1 (enable+lock), word1 lock bits without enables
    acc(1, 'h800, 32'h000F2200, 4'h6, 1, 0, 0, "R4 lock set");
    acc(0, 'h800, 0, 0, 1, 0, 32'h00000200, "R4 lock readback gated");
    // R3 locked lane dropped
    acc(1, 'h008, 32'hFFFFFFFF, 4'hF, 1, 1, 0, "R3 locked write err");
    acc(0, 'h008, 0, 0, 1, 0, 32'hFFFFC3FF, "R3 locked lane kept");
    // R4 clear via enable=1 lock=0
    acc(1, 'h800, 32'h00002000, 4'h2, 1, 0, 0, "R4 lock clear");
    acc(0, 'h800, 0, 0, 1, 0, 32'h0, "R4 cleared readback");
    acc(1, 'h008, 32'h00005500, 4'h2, 1, 0, 0, "R4 unlocked lane write");
    acc(0, 'h008, 0, 0, 1, 0, 32'hFFFF55FF, "R4 unlocked lane readback");
    // R5 alias write locks written lanes
    acc(1, 'h414, 32'h12345678, 4'hC, 1, 0, 0, "R5 alias write");
    acc(0, 'h014, 0, 0, 1, 0, 32'h12340000, "R5 normal readback");
    acc(0, 'h414, 0, 0, 1, 0, 32'h12340000, "R5 alias readback");
    acc(0, 'h804, 0, 0, 1, 0, 32'h000C0000, "R5 auto lock bits");
    acc(1, 'h014, 32'hFFFFFFFF, 4'hF, 1, 1, 0, "R5 locked after alias");
    acc(0, 'h014, 0, 0, 1, 0, 32'h1234FFFF, "R5 upper lanes kept");
    idle(); idle();
    // R8 user access gated by permit bit
    acc(0, 'h008, 0, 0, 0, 1, 32'h0, "R8 user read blocked");
    acc(1, 'h000, 32'h11111111, 4'hF, 0, 1, 0, "R8 user write blocked");
    acc(0, 'h000, 0, 0, 1, 0, 32'h0, "R8 blocked write no effect");
    acc(1, 'h900, 32'h00800000, 4'h4, 1, 0, 0, "R6 set permit");
    acc(0, 'h900, 0, 0, 1, 0, 32'h00800000, "R6 permit readback");
    acc(0, 'h008, 0, 0, 0, 0, 32'hFFFF55FF, "R8 user read allowed");
    // R9 unmapped
    acc(0, 'h300, 0, 0, 1, 1, 32'h0, "R9 unmapped read");
    acc(1, 'h300, 32'h1, 4'hF, 1, 1, 0, "R9 unmapped write");
    // R6/R7 freeze
    acc(1, 'h900, 32'h80800000, 4'hC, 1, 0, 0, "R6 set freeze");
    acc(0, 'h900, 0, 0, 1, 0, 32'h80800000, "R6 freeze readback");
    acc(1, 'h900, 32'h00000000, 4'hF, 1, 1, 0, "R7 ctrl write frozen");
    acc(0, 'h900, 0, 0, 1, 0, 32'h80800000, "R6 freeze sticky");
    acc(1, 'h800, 32'h00002200, 4'hF, 1, 1, 0, "R7 lock write frozen");
    acc(0, 'h800, 0, 0, 1, 0, 32'h0, "R7 locks unchanged");
    acc(1, 'h000, 32'h0000ABCD, 4'h3, 1, 0, 0, "R2 write while frozen");
    acc(0, 'h000, 0, 0, 1, 0, 32'h0000ABCD, "R2 readback while frozen");
    idle(); idle(); idle();
    vectors++;
    if (q_err.size() != 0) begin
      fails++;
      $display("FAIL R10 missing responses: actual %0d pending expected 0", q_err.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule